// File: doc/BRIEF.md
# Two-Segment Packet Stream Protocol Monitor

This block is a passive observer placed beside a 128-bit packet stream that is split into two 64-bit segments. Each segment has its own enable, start-of-packet, end-of-packet, error and empty-byte-count sideband. A single bus beat may therefore close one packet in segment 0 and open the next one in segment 1. The monitor never drives the stream. It follows the open/closed state of the current packet segment by segment, in order, and checks each beat against the protocol rules.

Each rule has one bit in a 9-bit violation vector. A rule that breaks in a cycle sets its bit in `pulse_o` for exactly one cycle. The same bit is set in `flag_o` and stays set. A synchronous `clr` input clears both vectors, the packet tracking state and the stall-hold tracking.

Both output vectors are registered. A violation caused by the inputs sampled at clock edge N appears in `pulse_o` and `flag_o` right after edge N. An integration bench or a live chip can read `flag_o` at any time to learn which rules have ever been broken since the last clear.

Top module: `strm_seg_monitor`

## Requirements
- R1: When a beat is accepted (s_tvalid=1 and s_tready=1) and more than one enabled segment carries SOP, bit 0 of the violation vector is raised.
- R2: When a beat is accepted and more than one enabled segment carries EOP, bit 1 is raised.
- R3: A segment takes part in packet tracking and rule checks only when s_tvalid, s_tready and its own enable are all 1. SOP/EOP/error/empty values on any other segment have no effect on either output vector.
- R4: An SOP on a transferred segment while a packet is already open raises bit 2 (missing EOP). The new packet is then treated as open.
- R5: A transferred segment with no packet open and no SOP raises bit 3 (missing SOP).
- R6: An error flag of 1 on a transferred segment without EOP raises bit 4. On a segment with EOP the error flag is legal.
- R7: A nonzero empty count (s_mty bits [3s+2:3s] for segment s) on a transferred segment without EOP raises bit 5. On a segment with EOP any empty count is legal.
- R8: In an accepted beat that starts with a packet open, the following case raises bit 6 (hole): segment 0 not enabled and segment 1 enabled.
- R9: The following case raises bit 7 (stability): in the cycle after s_tvalid=1 with s_tready=0, s_tvalid, any enable, SOP, EOP, error, empty count or data bit differs from the held value.
- R10: When s_tready=1, a packet is open, and either s_tvalid=0 or no segment is enabled, bit 8 (underflow) is raised.
- R11: The flag_o bits are sticky. Only clr (or reset) clears them. A clr cycle also clears pulse_o, closes any open packet and forgets any pending stall. All outputs are 0 after reset.
- R12: Segments are evaluated in order 0 then 1. A beat in which segment 0 carries EOP and segment 1 carries SOP raises no violation.
- R13: pulse_o reflects only the beat sampled at the previous clock edge. A clean beat that follows a violating beat gives pulse_o = 0 while flag_o keeps the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags, pulses and tracking state |
| s_tvalid | input | 1 | Observed source valid |
| s_tready | input | 1 | Observed sink ready |
| s_tdata | input | 128 | Observed payload, segment s in bits [64s+63:64s] |
| s_ena | input | 2 | Per-segment enable |
| s_sop | input | 2 | Per-segment start of packet |
| s_eop | input | 2 | Per-segment end of packet |
| s_err | input | 2 | Per-segment packet error marker |
| s_mty | input | 6 | Per-segment empty byte count, 3 bits each |
| flag_o | output | 9 | Sticky violation bits (bit map per R1..R10) |
| pulse_o | output | 9 | One-cycle violation bits, same map |

## Verification
The directed beats include several kinds of traffic. A straddled handover (EOP in segment 0, SOP in segment 1) separates correct in-order segment evaluation from evaluation that is per beat only. Double SOP/EOP beats check the beat-wide counts. Error and empty values placed on EOP and on non-EOP segments separate the sampled positions from the ignored ones. Stimulus with valid low, tready low or no enables shows that untransferred segments leave the tracking state alone, and it also starves an open packet to trigger underflow.

A stall with a changed payload exercises the hold rule. A clear issued in the middle of a packet shows that tracking restarts closed. Long random traffic, biased toward held stalls and sparse SOP/EOP, is compared bit by bit against a reference model in the bench. This catches interactions that the directed cases miss.

// File: rtl/strm_mon_pkg.sv
package strm_mon_pkg;

    localparam int NV          = 9;
    localparam int V_MULTI_SOP = 0;
    localparam int V_MULTI_EOP = 1;
    localparam int V_NO_EOP    = 2;
    localparam int V_NO_SOP    = 3;
    localparam int V_ERR_MID   = 4;
    localparam int V_MTY_MID   = 5;
    localparam int V_HOLE      = 6;
    localparam int V_UNSTABLE  = 7;
    localparam int V_UNDERFLOW = 8;

    typedef logic [NV-1:0] viol_vec_t;

    typedef struct packed {
        logic      open;
        viol_vec_t flag;
        viol_vec_t pulse;
    } mon_state_t;

endpackage

// File: rtl/strm_seg_eval.sv
module strm_seg_eval #(
    parameter int MW = 3
) (
    input  logic          live,
    input  logic          prev_live,
    input  logic          open_prev,
    input  logic          open_in,
    input  logic          sop,
    input  logic          eop,
    input  logic          err,
    input  logic [MW-1:0] mty,
    output logic          open_out,
    output logic          no_eop,
    output logic          no_sop,
    output logic          err_mid,
    output logic          mty_mid,
    output logic          hole
);

    logic open_mid;

    always_comb begin
        no_eop   = 1'b0;
        no_sop   = 1'b0;
        err_mid  = 1'b0;
        mty_mid  = 1'b0;
        hole     = open_prev && !prev_live && live;
        open_mid = open_in;
        open_out = open_in;
        if (live) begin
            if (sop) begin
                no_eop   = open_in;
                open_mid = 1'b1;
            end else if (!open_in) begin
                no_sop = 1'b1;
            end
            if (eop) begin
                open_out = 1'b0;
            end else begin
                open_out = open_mid;
                err_mid  = err;
                mty_mid  = (mty != '0);
            end
        end
    end

endmodule

// File: rtl/strm_hold_watch.sv
module strm_hold_watch #(
    parameter int BW = 143
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          valid,
    input  logic          ready,
    input  logic [BW-1:0] bundle,
    output logic          hit
);

    typedef struct packed {
        logic          stall;
        logic [BW-1:0] held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = st_q.stall && (bundle != st_q.held);
        if (clr) begin
            st_d.stall = 1'b0;
            st_d.held  = '0;
        end else begin
            st_d.stall = valid && !ready;
            st_d.held  = bundle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A beat that was stalled may not be withdrawn.
    assert_no_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stall && !valid && !clr) |-> hit);

endmodule

// File: rtl/strm_seg_monitor.sv
module strm_seg_monitor
    import strm_mon_pkg::*;
#(
    parameter int NSEG      = 2,
    parameter int SEG_BYTES = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            s_tvalid,
    input  logic                            s_tready,
    input  logic [NSEG*SEG_BYTES*8-1:0]     s_tdata,
    input  logic [NSEG-1:0]                 s_ena,
    input  logic [NSEG-1:0]                 s_sop,
    input  logic [NSEG-1:0]                 s_eop,
    input  logic [NSEG-1:0]                 s_err,
    input  logic [NSEG*$clog2(SEG_BYTES)-1:0] s_mty,
    output logic [NV-1:0]                   flag_o,
    output logic [NV-1:0]                   pulse_o
);

    localparam int DW = NSEG * SEG_BYTES * 8;
    localparam int MW = $clog2(SEG_BYTES);
    localparam int BW = 1 + 4 * NSEG + NSEG * MW + DW;

    mon_state_t st_d, st_q;

    logic            fire;
    logic [NSEG-1:0] live;
    logic [NSEG:0]   open_chain;
    logic [NSEG-1:0] h_no_eop, h_no_sop, h_err, h_mty, h_hole;
    logic            hold_hit;
    viol_vec_t       hits;

    assign fire          = s_tvalid && s_tready;
    assign live          = fire ? s_ena : '0;
    assign open_chain[0] = st_q.open;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic prev_live_s;
        logic open_prev_s;
        if (s == 0) begin : g_first
            assign prev_live_s = 1'b0;
            assign open_prev_s = 1'b0;
        end else begin : g_rest
            assign prev_live_s = live[s-1];
            assign open_prev_s = open_chain[s-1];
        end
        strm_seg_eval #(.MW(MW)) u_eval (
            .live      (live[s]),
            .prev_live (prev_live_s),
            .open_prev (open_prev_s),
            .open_in   (open_chain[s]),
            .sop       (s_sop[s]),
            .eop       (s_eop[s]),
            .err       (s_err[s]),
            .mty       (s_mty[s*MW +: MW]),
            .open_out  (open_chain[s+1]),
            .no_eop    (h_no_eop[s]),
            .no_sop    (h_no_sop[s]),
            .err_mid   (h_err[s]),
            .mty_mid   (h_mty[s]),
            .hole      (h_hole[s])
        );
    end

    strm_hold_watch #(.BW(BW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .valid  (s_tvalid),
        .ready  (s_tready),
        .bundle ({s_tvalid, s_ena, s_sop, s_eop, s_err, s_mty, s_tdata}),
        .hit    (hold_hit)
    );

    always_comb begin
        hits              = '0;
        hits[V_MULTI_SOP] = $countones(live & s_sop) > 1;
        hits[V_MULTI_EOP] = $countones(live & s_eop) > 1;
        hits[V_NO_EOP]    = |h_no_eop;
        hits[V_NO_SOP]    = |h_no_sop;
        hits[V_ERR_MID]   = |h_err;
        hits[V_MTY_MID]   = |h_mty;
        hits[V_HOLE]      = |h_hole;
        hits[V_UNSTABLE]  = hold_hit;
        hits[V_UNDERFLOW] = s_tready && st_q.open && (!s_tvalid || (s_ena == '0));

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.open  = open_chain[NSEG];
            st_d.pulse = hits;
            st_d.flag  = st_q.flag | hits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign pulse_o = st_q.pulse;

    assert_multi_sop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && ((s_ena & s_sop) == '1)) |=> pulse_o[V_MULTI_SOP]);

    assert_multi_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr && ((s_ena & s_eop) == '1)) |=> pulse_o[V_MULTI_EOP]);

    assert_starved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tready && !s_tvalid && st_q.open && !clr) |=> pulse_o[V_UNDERFLOW]);

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flag_o == '0 && pulse_o == '0));

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

endmodule

// File: tb/strm_seg_monitor_tb.sv
module strm_seg_monitor_tb;

    localparam int W  = 128;
    localparam int NV = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic tv = 1'b0, tr = 1'b0;
    logic [W-1:0] td = '0;
    logic [1:0] en = '0, so = '0, eo = '0, er = '0;
    logic [5:0] mt = '0;
    logic [NV-1:0] flag_o, pulse_o;

    always #10 clk = ~clk;

    strm_seg_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .s_tvalid(tv), .s_tready(tr), .s_tdata(td),
        .s_ena(en), .s_sop(so), .s_eop(eo), .s_err(er), .s_mty(mt),
        .flag_o(flag_o), .pulse_o(pulse_o)
    );

    int n_chk = 0, n_bad = 0;
    string tag [NV] = '{"R1", "R2", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};

    // reference model state
    logic m_open = 1'b0, m_stall = 1'b0;
    logic [NV-1:0] m_flag = '0;
    logic p_tv = 1'b0;
    logic [W-1:0] p_td = '0;
    logic [1:0] p_en = '0, p_so = '0, p_eo = '0, p_er = '0;
    logic [5:0] p_mt = '0;
    logic [NV-1:0] last_exp = '0;

    task automatic check(string req, logic [NV-1:0] act, logic [NV-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [NV-1:0] model(output logic open_out);
        logic [NV-1:0] h = '0;
        logic fire = tv && tr;
        logic o = m_open;
        logic po = 1'b0, pl = 1'b0;
        if (fire && $countones(en & so) > 1) h[0] = 1'b1;
        if (fire && $countones(en & eo) > 1) h[1] = 1'b1;
        for (int s = 0; s < 2; s++) begin
            logic live = fire && en[s];
            if (s > 0 && po && !pl && live) h[6] = 1'b1;
            po = o;
            pl = live;
            if (live) begin
                if (so[s]) begin
                    if (o) h[2] = 1'b1;
                    o = 1'b1;
                end else if (!o) begin
                    h[3] = 1'b1;
                end
                if (eo[s]) o = 1'b0;
                else begin
                    if (er[s]) h[4] = 1'b1;
                    if (mt[s*3 +: 3] != 3'd0) h[5] = 1'b1;
                end
            end
        end
        if (tr && m_open && (!tv || en == 2'b00)) h[8] = 1'b1;
        if (m_stall && (tv !== p_tv || td !== p_td || en !== p_en || so !== p_so ||
                        eo !== p_eo || er !== p_er || mt !== p_mt)) h[7] = 1'b1;
        open_out = o;
        return h;
    endfunction

    // Inputs are set at a negedge; sample one clock later at the next negedge.
    task automatic step();
        logic nopen;
        logic [NV-1:0] exp = model(nopen);
        if (clr) exp = '0;
        @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < NV; b++) check(tag[b], pulse_o[b], exp[b]);
        if (clr) begin
            m_open = 1'b0; m_stall = 1'b0; m_flag = '0;
        end else begin
            m_open = nopen; m_flag |= exp; m_stall = tv && !tr;
        end
        check("R11", flag_o, m_flag);
        p_tv = tv; p_td = td; p_en = en; p_so = so; p_eo = eo; p_er = er; p_mt = mt;
        last_exp = exp;
    endtask

    task automatic beat(logic v, logic r, logic [1:0] e, logic [1:0] s, logic [1:0] q,
                        logic [1:0] x, logic [5:0] m);
        tv = v; tr = r; en = e; so = s; eo = q; er = x; mt = m;
        td = {$urandom, $urandom, $urandom, $urandom};
        step();
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset flags", flag_o, '0);
        check("R11 reset pulses", pulse_o, '0);

        // R12 straddled handover
        beat(1, 1, 2'b11, 2'b01, 2'b00, 0, 0);
        beat(1, 1, 2'b11, 2'b10, 2'b01, 0, 0);
        check("R12 handover", pulse_o, '0);
        beat(1, 1, 2'b01, 2'b00, 2'b01, 0, 6'o05);
        check("R7 mty on eop legal", pulse_o, '0);
        beat(0, 1, 0, 0, 0, 0, 0);
        check("R10 closed idle no underflow", pulse_o, '0);

        // R3 untransferred segments
        beat(0, 1, 2'b11, 2'b11, 2'b11, 2'b11, 6'o77);
        check("R3 tvalid low", pulse_o, '0);
        beat(1, 1, 2'b00, 2'b11, 2'b11, 2'b11, 6'o77);
        check("R3 no enable", pulse_o, '0);
        beat(1, 0, 2'b11, 2'b11, 2'b11, 2'b11, 6'o77);
        check("R3 tready low", pulse_o, '0);
        beat(1, 0, 2'b11, 2'b11, 2'b11, 2'b11, 6'o77);
        check("R9 stall with changed data", pulse_o, 9'b010000000);

        // R1 R2 double markers
        beat(1, 1, 2'b11, 2'b11, 2'b11, 0, 0);
        check("R1 R2 double sop eop", pulse_o[1:0], 2'b11);
        beat(1, 1, 2'b01, 2'b01, 2'b01, 2'b01, 0);
        check("R6 err on eop legal", pulse_o, '0);
        check("R13 pulse clears", flag_o[1:0], 2'b11);

        // R6 R7 mid-packet markers, R10 starvation, R8 hole
        beat(1, 1, 2'b01, 2'b01, 2'b00, 2'b01, 6'o03);
        check("R6 R7 mid markers", pulse_o, 9'b000110000);
        beat(0, 1, 0, 0, 0, 0, 0);
        check("R10 starved", pulse_o, 9'b100000000);
        beat(1, 1, 2'b10, 2'b00, 2'b10, 0, 0);
        check("R8 hole", pulse_o, 9'b001000000);
        beat(1, 1, 2'b01, 2'b00, 2'b01, 0, 0);
        check("R5 eop no sop", pulse_o, 9'b000001000);

        // R4 sop while open
        beat(1, 1, 2'b01, 2'b01, 2'b00, 0, 0);
        beat(1, 1, 2'b10, 2'b10, 2'b00, 0, 0);
        check("R4 sop while open", pulse_o[2], 1'b1);

        // R11 clear mid-packet
        clr = 1'b1;
        step();
        check("R11 clear flags", flag_o, '0);
        clr = 1'b0;
        beat(1, 1, 2'b01, 2'b00, 2'b00, 0, 0);
        check("R11 R5 tracking restarted closed", pulse_o, 9'b000001000);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if (m_stall && ($urandom % 100) < 85) begin
                tv = p_tv; td = p_td; en = p_en; so = p_so; eo = p_eo; er = p_er; mt = p_mt;
            end else begin
                tv = ($urandom % 100) < 80;
                en = ($urandom % 100) < 70 ? 2'b11 : 2'($urandom);
                so = {($urandom % 100) < 20, ($urandom % 100) < 20};
                eo = {($urandom % 100) < 25, ($urandom % 100) < 25};
                er = {($urandom % 100) < 5, ($urandom % 100) < 5};
                mt = ($urandom % 100) < 15 ? 6'($urandom) : 6'd0;
                td = {$urandom, $urandom, $urandom, $urandom};
            end
            tr = ($urandom % 100) < 80;
            clr = ($urandom % 100) < 1;
            step();
        end
        clr = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule